// File: doc/BRIEF.md
# Clock Control Register Bank

This block is a memory-mapped bank of twenty-eight 32-bit clock control words, together with a combinational calculator. From the contents of the clock control word and an input value for the main PLL frequency, the calculator derives three frequencies: the CPU core clock, the AHB bus clock and the peripheral clock. Software sees only full-word, aligned accesses inside a 112-byte window. Any other access is refused with an error flag. A timer or driver model elsewhere on the chip reads the frequency outputs to learn the rates it runs at.

Each request receives one registered response in the next cycle. The response carries the read data and an error bit. The frequency outputs follow the stored control word and the PLL input in the same cycle, so a write to the control word shows on them right after the clock edge that stores it. A select input picks one of the derived clocks, or the fixed slow reference, and reports its rate on a separate output.

Top module: `clkctl_regbank`

## Requirements
- R1: Offsets 0x00 through 0x6C address 28 word registers, numbered by offset divided by four. A legal write stores all 32 bits with no masking, and a later read of the same offset returns that value.
- R2: An access at offset 0x70 or above sets the error bit in its response. If it is a read, it returns zero. If it is a write, it changes no register.
- R3: An access whose size code is not 2'b10 (4 bytes), or whose address has bits [1:0] not zero, is refused in the same way: the error bit is set, a read returns zero and a write changes nothing.
- R4: rsp_valid is high in exactly the cycle after a cycle with req_valid high, and is low at all other times, including just after reset. Responses to writes carry zero data.
- R5: After reset the registers hold these values, by index:
  - 0: 0x800B2C01
  - 1: 0x84042800
  - 2: 0xD0030000
  - 3: 0x028A0100
  - 4: 0x04008100
  - 5: 0x00000438
  - 6 to 9: 0x01010101
  - 22: 0x00A00000
  - 23 and 24: 0x0000A030
  - 25: 0x43000000
  - every other index: zero.
- R6: When bit 22 of the clock control word (index 2) is set, the clock source is 24,000,000 Hz. When it is clear, the source is pll_hz.
- R7: When bit 14 of the clock control word is set, the source is first scaled to floor(source*3/4), with no loss for sources up to 2^32-1. The core frequency is then the scaled value divided by (1 + bits [31:30]), truncated.
- R8: bus_hz equals core_hz divided by (1 + bits [29:28]), truncated. periph_hz equals bus_hz divided by 2, truncated.
- R9: The selection code on clk_sel gives these results on sel_hz, with sel_err low:
  - 0: zero
  - 1 or 2: periph_hz
  - 3: 32768.
  Codes 4 to 7 give zero with sel_err high.
- R10: After reset, with pll_hz at 532,000,000, the outputs are 133,000,000 core, 66,500,000 bus and 33,250,000 peripheral.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 12 | Byte offset of the access |
| req_size | input | 2 | Access size code; only 2'b10 (4 bytes) is legal |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Access was refused |
| rsp_rdata | output | 32 | Read data, zero for refused reads and for writes |
| pll_hz | input | 32 | Main PLL frequency in Hz |
| clk_sel | input | 3 | Clock selection code |
| core_hz | output | 32 | CPU core clock frequency |
| bus_hz | output | 32 | AHB bus clock frequency |
| periph_hz | output | 32 | Peripheral clock frequency |
| sel_hz | output | 32 | Frequency of the selected clock |
| sel_err | output | 1 | Unsupported selection code |

## Verification
The assertions check several properties in every cycle:
- the one-cycle response timing;
- zero data on refused responses;
- register contents left unchanged in cycles without a legal write;
- bus and peripheral rates never above the core rate;
- the fixed slow and unsupported selection results.

Only the bench scenarios can show three things: the exact reset word of each register, that a write lands in the addressed register, and the exact quotients with truncation and the three-quarter scaling. It runs a table of control word and PLL pairs, including a source above 2^32/3, where a 32-bit product would overflow.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
    localparam int REG_COUNT   = 28;
    localparam int IDX_W       = $clog2(REG_COUNT);
    localparam int WORD_W      = 32;
    localparam int XTAL_HZ     = 24_000_000;
    localparam int SLOW_HZ     = 32_768;
    localparam int IDX_CLKCTL  = 2;
    localparam int BYPASS_BIT  = 22;
    localparam int QSRC_BIT    = 14;
    localparam int CDIV_LSB    = 30;
    localparam int BDIV_LSB    = 28;
    localparam int DIV_W       = 2;
    localparam logic [1:0] SIZE_WORD = 2'b10;

    localparam logic [2:0] SEL_NONE      = 3'd0;
    localparam logic [2:0] SEL_PERIPH    = 3'd1;
    localparam logic [2:0] SEL_PERIPH_HI = 3'd2;
    localparam logic [2:0] SEL_SLOW      = 3'd3;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [WORD_W-1:0] rdata;
    } rsp_t;

    function automatic logic [WORD_W-1:0] reset_word(input int idx);
        case (idx)
            0:           return 32'h800B_2C01;
            1:           return 32'h8404_2800;
            2:           return 32'hD003_0000;
            3:           return 32'h028A_0100;
            4:           return 32'h0400_8100;
            5:           return 32'h0000_0438;
            6, 7, 8, 9:  return 32'h0101_0101;
            22:          return 32'h00A0_0000;
            23, 24:      return 32'h0000_A030;
            25:          return 32'h4300_0000;
            default:     return '0;
        endcase
    endfunction
endpackage

// File: rtl/clkctl_bus_decode.sv
module clkctl_bus_decode
    import clkctl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output logic              legal,
    output logic              rd_en,
    output logic              wr_en,
    output logic [IDX_W-1:0]  idx
);
    localparam int WINDOW_BYTES = REG_COUNT * 4;

    logic in_window;
    logic aligned;
    logic [ADDR_W-3:0] word_addr;

    always_comb begin
        word_addr = req_addr[ADDR_W-1:2];
        in_window = (32'(req_addr) < WINDOW_BYTES);
        aligned   = (req_addr[1:0] == 2'b00);
        legal     = in_window && aligned && (req_size == SIZE_WORD);
        rd_en     = req_valid && !req_write && legal;
        wr_en     = req_valid &&  req_write && legal;
        idx       = IDX_W'(word_addr);
    end
endmodule

// File: rtl/clkctl_reg_file.sv
module clkctl_reg_file
    import clkctl_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [WORD_W-1:0]                 wr_data,
    output logic [REG_COUNT-1:0][WORD_W-1:0]  regs_q
);
    logic [REG_COUNT-1:0][WORD_W-1:0] regs_d;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                regs_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_COUNT; i++) begin
                regs_q[i] <= reset_word(i);
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    // R2 / R3: no register moves without a legal write
    a_r3_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));
endmodule

// File: rtl/clkctl_freq_calc.sv
module clkctl_freq_calc
    import clkctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass,
    input  logic              quarter_src,
    input  logic [DIV_W-1:0]  core_div,
    input  logic [DIV_W-1:0]  bus_div,
    input  logic [WORD_W-1:0] pll_hz,
    input  logic [2:0]        clk_sel,
    output logic [WORD_W-1:0] core_hz,
    output logic [WORD_W-1:0] bus_hz,
    output logic [WORD_W-1:0] periph_hz,
    output logic [WORD_W-1:0] sel_hz,
    output logic              sel_err
);
    localparam int WIDE_W = WORD_W + 2;

    logic [WIDE_W-1:0] src_w;
    logic [WIDE_W-1:0] scaled_w;
    logic [WIDE_W-1:0] core_w;

    always_comb begin
        src_w     = bypass ? WIDE_W'(XTAL_HZ) : WIDE_W'(pll_hz);
        scaled_w  = quarter_src ? ((src_w * WIDE_W'(3)) >> 2) : src_w;
        core_w    = scaled_w / (WIDE_W'(core_div) + WIDE_W'(1));
        core_hz   = WORD_W'(core_w);
        bus_hz    = core_hz / (WORD_W'(bus_div) + WORD_W'(1));
        periph_hz = bus_hz >> 1;
        sel_err   = 1'b0;
        case (clk_sel)
            SEL_NONE:                  sel_hz = '0;
            SEL_PERIPH, SEL_PERIPH_HI: sel_hz = periph_hz;
            SEL_SLOW:                  sel_hz = WORD_W'(SLOW_HZ);
            default: begin
                sel_hz  = '0;
                sel_err = 1'b1;
            end
        endcase
    end

    a_r8_bus_not_above_core: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_hz <= core_hz) && (periph_hz <= bus_hz));
    a_r9_slow_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == SEL_SLOW) |-> (sel_hz == 32'd32768) && !sel_err);
    a_r9_unsupported: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel[2] |-> sel_err && (sel_hz == '0));
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
    import clkctl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    input  logic [31:0]       pll_hz,
    input  logic [2:0]        clk_sel,
    output logic [31:0]       core_hz,
    output logic [31:0]       bus_hz,
    output logic [31:0]       periph_hz,
    output logic [31:0]       sel_hz,
    output logic              sel_err
);
    logic                              legal;
    logic                              rd_en;
    logic                              wr_en;
    logic [IDX_W-1:0]                  idx;
    logic [REG_COUNT-1:0][WORD_W-1:0]  regs;
    logic [WORD_W-1:0]                 ctl_word;
    logic [WORD_W-1:0]                 rd_word;
    rsp_t                              rsp_d;
    rsp_t                              rsp_q;

    clkctl_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .legal     (legal),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .idx       (idx)
    );

    clkctl_reg_file u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_data (req_wdata),
        .regs_q  (regs)
    );

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (idx == IDX_W'(i)) begin
                rd_word = regs[i];
            end
        end
        rsp_d.valid = req_valid;
        rsp_d.err   = req_valid && !legal;
        rsp_d.rdata = rd_en ? rd_word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;
    assign ctl_word  = regs[IDX_CLKCTL];

    clkctl_freq_calc u_freq (
        .clk         (clk),
        .rst_n       (rst_n),
        .bypass      (ctl_word[BYPASS_BIT]),
        .quarter_src (ctl_word[QSRC_BIT]),
        .core_div    (ctl_word[CDIV_LSB +: DIV_W]),
        .bus_div     (ctl_word[BDIV_LSB +: DIV_W]),
        .pll_hz      (pll_hz),
        .clk_sel     (clk_sel),
        .core_hz     (core_hz),
        .bus_hz      (bus_hz),
        .periph_hz   (periph_hz),
        .sel_hz      (sel_hz),
        .sel_err     (sel_err)
    );

    a_r4_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r4_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r2_refused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));
    a_r3_bad_size_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_size != 2'b10)) |=> rsp_err);
endmodule

// File: tb/clkctl_regbank_tb.sv
module clkctl_regbank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = 2'b10;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;
    logic [31:0] pll_hz = 32'd532_000_000;
    logic [2:0]  clk_sel = 3'd0;
    logic [31:0] core_hz, bus_hz, periph_hz, sel_hz;
    logic        sel_err;

    int n_checks = 0;
    int n_fail = 0;
    logic        got_valid, got_err;
    logic [31:0] got_data;

    always #5 clk = ~clk;

    clkctl_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .pll_hz(pll_hz), .clk_sel(clk_sel), .core_hz(core_hz), .bus_hz(bus_hz),
        .periph_hz(periph_hz), .sel_hz(sel_hz), .sel_err(sel_err)
    );

    // vector: control word, pll, expected core, bus, peripheral
    localparam int NVEC = 7;
    localparam logic [4:0][31:0] VEC [NVEC] = '{
        '{32'hD003_0000, 32'd532_000_000, 32'd133_000_000, 32'd66_500_000, 32'd33_250_000},
        '{32'h0040_0000, 32'd500_000_000, 32'd24_000_000,  32'd24_000_000, 32'd12_000_000},
        '{32'h0000_4000, 32'd400_000_000, 32'd300_000_000, 32'd300_000_000, 32'd150_000_000},
        '{32'h6000_4000, 32'd532_000_000, 32'd199_500_000, 32'd66_500_000, 32'd33_250_000},
        '{32'hF040_4000, 32'd532_000_000, 32'd4_500_000,   32'd1_125_000,  32'd562_500},
        '{32'h8000_0000, 32'd100_000_001, 32'd33_333_333,  32'd33_333_333, 32'd16_666_666},
        '{32'h0000_4000, 32'd4_000_000_000, 32'd3_000_000_000, 32'd3_000_000_000, 32'd1_500_000_000}
    };

    function automatic logic [31:0] exp_reset(input int i);
        if (i == 0) return 32'h800B_2C01;
        if (i == 1) return 32'h8404_2800;
        if (i == 2) return 32'hD003_0000;
        if (i == 3) return 32'h028A_0100;
        if (i == 4) return 32'h0400_8100;
        if (i == 5) return 32'h0000_0438;
        if (i >= 6 && i <= 9) return 32'h0101_0101;
        if (i == 22) return 32'h00A0_0000;
        if (i == 23 || i == 24) return 32'h0000_A030;
        if (i == 25) return 32'h4300_0000;
        return 32'h0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [11:0] addr,
                          input logic [1:0] size, input logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = size; req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
        got_valid = rsp_valid; got_err = rsp_err; got_data = rsp_rdata;
    endtask

    initial begin
        #200_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 idle after reset", {31'd0, rsp_valid}, 32'd0);
        check("R10 core", core_hz, 32'd133_000_000);
        check("R10 bus", bus_hz, 32'd66_500_000);
        check("R10 periph", periph_hz, 32'd33_250_000);

        for (int i = 0; i < 28; i++) begin
            access(1'b0, 12'(i * 4), 2'b10, '0);
            check("R5 reset word", got_data, exp_reset(i));
        end
        check("R4 read response valid", {31'd0, got_valid}, 32'd1);
        check("R4 read no error", {31'd0, got_err}, 32'd0);

        // R2 outside window
        access(1'b1, 12'h070, 2'b10, 32'hDEAD_BEEF);
        check("R2 write outside err", {31'd0, got_err}, 32'd1);
        check("R4 write data zero", got_data, 32'd0);
        access(1'b0, 12'h070, 2'b10, '0);
        check("R2 read outside err", {31'd0, got_err}, 32'd1);
        check("R2 read outside zero", got_data, 32'd0);
        access(1'b0, 12'h000, 2'b10, '0);
        check("R2 write outside ignored", got_data, 32'h800B_2C01);
        access(1'b0, 12'hFFC, 2'b10, '0);
        check("R2 far read err", {31'd0, got_err}, 32'd1);

        // R3 misaligned and wrong size
        access(1'b1, 12'h00A, 2'b10, 32'h1234_5678);
        check("R3 misaligned write err", {31'd0, got_err}, 32'd1);
        access(1'b0, 12'h008, 2'b10, '0);
        check("R3 misaligned write ignored", got_data, 32'hD003_0000);
        access(1'b1, 12'h00C, 2'b01, 32'h1234_5678);
        check("R3 half write err", {31'd0, got_err}, 32'd1);
        access(1'b0, 12'h00C, 2'b10, '0);
        check("R3 half write ignored", got_data, 32'h028A_0100);
        access(1'b0, 12'h00C, 2'b00, '0);
        check("R3 byte read err", {31'd0, got_err}, 32'd1);
        check("R3 byte read zero", got_data, 32'd0);
        @(negedge clk);
        check("R4 idle no response", {31'd0, rsp_valid}, 32'd0);

        // R1 full-word write and readback
        for (int i = 0; i < 28; i++) begin
            access(1'b1, 12'(i * 4), 2'b10, 32'hA5C3_0000 ^ (32'(i) * 32'h0101_0107));
            check("R1 write no err", {31'd0, got_err}, 32'd0);
        end
        for (int i = 0; i < 28; i++) begin
            access(1'b0, 12'(i * 4), 2'b10, '0);
            check("R1 readback", got_data, 32'hA5C3_0000 ^ (32'(i) * 32'h0101_0107));
        end

        // R6 R7 R8 table
        for (int v = 0; v < NVEC; v++) begin
            pll_hz = VEC[v][3];
            access(1'b1, 12'h008, 2'b10, VEC[v][4]);
            #1;
            check("R6/R7 core", core_hz, VEC[v][2]);
            check("R8 bus", bus_hz, VEC[v][1]);
            check("R8 periph", periph_hz, VEC[v][0]);
        end

        // R9 selection codes (last vector: periph 1_500_000_000)
        for (int s = 0; s < 8; s++) begin
            clk_sel = 3'(s);
            #1;
            if (s == 0) check("R9 none", sel_hz, 32'd0);
            else if (s <= 2) check("R9 periph", sel_hz, 32'd1_500_000_000);
            else if (s == 3) check("R9 slow", sel_hz, 32'd32768);
            else check("R9 unsupported", sel_hz, 32'd0);
            check("R9 error flag", {31'd0, sel_err}, (s >= 4) ? 32'd1 : 32'd0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule